// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one column access into the full list of column addresses that a synchronous DRAM burst visits, one per clock. A request supplies the starting column, a burst-length code and an ordering choice (linear wrap or XOR-based wrap). From the next clock on, the block presents one column address per cycle, together with a valid flag and a flag that marks the final beat of a fixed-length burst.

Open-ended full-page bursts step through every column of the page and wrap at the page boundary. They run until a stop input is seen. The page size follows the device organisation, which is chosen by a parameter. A fresh request may arrive on any clock. It replaces whatever burst is in progress, so a controller can issue a new random column every cycle. The block can serve as the column sequencer inside a memory model, or on the controller side to tag which word returns on each beat.

Top module: `burst_col_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the cycle after that edge shows `col_valid` and `col_last` low.
- R2: When `start` is sampled high, the next cycle shows `col_valid` high and `col_addr` equal to the sampled `start_col`. This happens whatever burst was in progress and whatever the `stop` input was doing.
- R3: With `wrap_il` low and `blen_code` 3'b001, 3'b010 or 3'b011 (bursts of 2, 4 or 8, k = 1, 2 or 3), beat n keeps every bit of `start_col` above bit k-1. Its low k bits equal (low k bits of `start_col` + n) mod burst length.
- R4: With `wrap_il` high and a burst of 2, 4 or 8, beat n presents `start_col` XOR n.
- R5: `blen_code` 3'b111 selects a full-page burst. Beat n presents (`start_col` + n) mod page size. `wrap_il` has no effect, the burst never ends by itself, and `col_last` stays low throughout.
- R6: `col_last` is high exactly on the final beat of a fixed-length burst. The cycle after it shows `col_valid` low, unless a new `start` was sampled.
- R7: `blen_code` 3'b000 (burst of 1), and the unused codes 3'b100 to 3'b110, produce a single beat equal to `start_col`, with `col_last` high on that same beat.
- R8: `stop` sampled high without `start`, while a burst is active, makes the next cycle show `col_valid` low.
- R9: The page size is 2048, 1024 or 512 columns for `ORG_SEL` 0, 1 or 2. `col_addr` is 11, 10 or 9 bits wide to match, and a full-page burst wraps from the last column to column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load a new burst from `start_col` |
| start_col | input | COL_W | Starting column of the burst |
| blen_code | input | 3 | Burst length: 000=1, 001=2, 010=4, 011=8, 111=full page, others=1 |
| wrap_il | input | 1 | 1 = XOR (interleaved) order, 0 = linear order |
| stop | input | 1 | Terminate the active burst |
| col_valid | output | 1 | A column address is presented this cycle |
| col_addr | output | COL_W | Column address of the current beat |
| col_last | output | 1 | Final beat of a fixed-length burst |

## Verification
The bench builds the block with `ORG_SEL` = 2, which gives a 512-column page. With this page size, a full-page burst crosses the page boundary within a few hundred cycles, so the wrap from column 511 to 0 is exercised both in a directed case and under random stop timing. Every burst code, including the unused ones, is also reached in random traffic. That traffic includes back-to-back starts and starts that collide with stop.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

    localparam logic [2:0] CODE_BL1  = 3'b000;
    localparam logic [2:0] CODE_BL2  = 3'b001;
    localparam logic [2:0] CODE_BL4  = 3'b010;
    localparam logic [2:0] CODE_BL8  = 3'b011;
    localparam logic [2:0] CODE_PAGE = 3'b111;

    typedef struct packed {
        logic [2:0] code;
        logic       il;
    } burst_cfg_t;

    // Page column bits per device organisation (R9)
    function automatic int page_bits(input int org);
        case (org)
            0:       return 11;
            1:       return 10;
            default: return 9;
        endcase
    endfunction

    // log2 of a fixed burst length; 0 for single-beat and unused codes
    function automatic logic [1:0] wrap_bits(input logic [2:0] code);
        case (code)
            CODE_BL2: return 2'd1;
            CODE_BL4: return 2'd2;
            CODE_BL8: return 2'd3;
            default:  return 2'd0;
        endcase
    endfunction

    function automatic logic is_page(input logic [2:0] code);
        return code == CODE_PAGE;
    endfunction

endpackage

// File: rtl/col_addr_map.sv
module col_addr_map
    import burst_col_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    input  burst_cfg_t       cfg,
    output logic [COL_W-1:0] addr
);
    logic             pg;
    logic [1:0]       wb;
    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] lin;
    logic [COL_W-1:0] xr;
    logic [COL_W-1:0] low;

    assign pg = is_page(cfg.code);
    assign wb = wrap_bits(cfg.code);

    // Per-bit wrap mask: bits below the burst size, or all bits on a full page
    for (genvar g = 0; g < COL_W; g++) begin : g_mask
        assign mask[g] = pg | (int'(wb) > g);
    end

    assign lin  = base + beat;
    assign xr   = base ^ beat;
    assign low  = (cfg.il && !pg) ? xr : lin;
    assign addr = (base & ~mask) | (low & mask);

endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
    import burst_col_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  burst_cfg_t       cfg_in,
    input  logic             stop,
    output logic             active,
    output logic [COL_W-1:0] base,
    output logic [COL_W-1:0] beat,
    output burst_cfg_t       cfg,
    output logic             last
);
    logic [COL_W-1:0] len_m1;
    logic             pg;

    assign pg     = is_page(cfg.code);
    assign len_m1 = COL_W'((1 << wrap_bits(cfg.code)) - 1);
    assign last   = active && !pg && (beat == len_m1);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            base   <= '0;
            beat   <= '0;
            cfg    <= '0;
        end else if (start) begin
            active <= 1'b1;
            base   <= start_col;
            beat   <= '0;
            cfg    <= cfg_in;
        end else if (active) begin
            if (stop || last) begin
                active <= 1'b0;
            end else begin
                beat <= beat + 1'b1;
            end
        end
    end

    // R5: a full-page burst never flags a final beat
    a_r5_page_no_last: assert property (@(posedge clk) disable iff (rst)
        (active && pg) |-> !last);

    // R6: after the final beat the burst ends unless reloaded
    a_r6_last_ends: assert property (@(posedge clk) disable iff (rst)
        (last && !start) |=> !active);

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import burst_col_pkg::*;
#(
    parameter int ORG_SEL = 2,
    localparam int COL_W  = page_bits(ORG_SEL)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic [2:0]       blen_code,
    input  logic             wrap_il,
    input  logic             stop,
    output logic             col_valid,
    output logic [COL_W-1:0] col_addr,
    output logic             col_last
);
    burst_cfg_t       cfg_in;
    burst_cfg_t       cfg_q;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] beat_q;
    logic             active_q;
    logic             last_q;

    assign cfg_in = '{code: blen_code, il: wrap_il};

    burst_seq_ctrl #(.COL_W(COL_W)) seq_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .start_col (start_col),
        .cfg_in    (cfg_in),
        .stop      (stop),
        .active    (active_q),
        .base      (base_q),
        .beat      (beat_q),
        .cfg       (cfg_q),
        .last      (last_q)
    );

    col_addr_map #(.COL_W(COL_W)) map_i (
        .base (base_q),
        .beat (beat_q),
        .cfg  (cfg_q),
        .addr (col_addr)
    );

    assign col_valid = active_q;
    assign col_last  = last_q;

    // R1: reset clears the outputs
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!col_valid && !col_last));

    // R2: a sampled start presents the start column next cycle
    a_r2_load: assert property (@(posedge clk) disable iff (rst)
        start |=> (col_valid && col_addr == $past(start_col)));

    // R6: the final-beat flag only appears on a valid beat
    a_r6_last_valid: assert property (@(posedge clk) disable iff (rst)
        col_last |-> col_valid);

    // R7: single-beat codes flag the final beat immediately
    a_r7_single: assert property (@(posedge clk) disable iff (rst)
        (start && wrap_bits(blen_code) == 2'd0 && !is_page(blen_code)) |=> col_last);

    // R8: stop without start ends the burst
    a_r8_stop: assert property (@(posedge clk) disable iff (rst)
        (stop && !start) |=> !col_valid);

endmodule

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb_top;
    localparam int PG = 512;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [8:0] start_col = '0;
    logic [2:0] blen_code = '0;
    logic       wrap_il = 1'b0;
    logic       stop = 1'b0;
    logic       col_valid;
    logic [8:0] col_addr;
    logic       col_last;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // bench model of the burst
    bit m_active = 0;
    int m_base = 0;
    int m_beat = 0;
    int m_len = 1;
    bit m_il = 0;

    always #4 clk = ~clk;

    burst_col_gen #(.ORG_SEL(2)) dut_i (
        .clk(clk), .rst(rst), .start(start), .start_col(start_col),
        .blen_code(blen_code), .wrap_il(wrap_il), .stop(stop),
        .col_valid(col_valid), .col_addr(col_addr), .col_last(col_last)
    );

    function automatic int len_of(input logic [2:0] c);
        case (c)
            3'b001: return 2;
            3'b010: return 4;
            3'b011: return 8;
            3'b111: return 0;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_addr();
        if (m_len == 0) return (m_base + m_beat) % PG;
        if (m_il && m_len > 1) return m_base ^ m_beat;
        return (m_base - (m_base % m_len)) + ((m_base % m_len) + m_beat) % m_len;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic check_outputs();
        chk(col_valid == m_active, "R2/R8 valid", int'(col_valid), int'(m_active));
        if (m_active) begin
            string t;
            bit el;
            if (m_len == 0) t = ((m_base + m_beat) >= PG) ? "R9 page wrap" : "R5 page";
            else if (m_len == 1) t = "R7 single";
            else if (m_il) t = "R4 xor";
            else t = "R3 linear";
            chk(int'(col_addr) == exp_addr(), t, int'(col_addr), exp_addr());
            el = (m_len != 0) && (m_beat == m_len - 1);
            chk(col_last == el, (m_len == 0) ? "R5 last" : "R6 last", int'(col_last), int'(el));
        end else begin
            chk(col_last == 1'b0, "R6 last idle", int'(col_last), 0);
        end
    endtask

    task automatic step(input bit s, input int col, input logic [2:0] code,
                        input bit il, input bit st);
        @(negedge clk);
        check_outputs();
        start = s; start_col = 9'(col); blen_code = code; wrap_il = il; stop = st;
        if (s) begin
            m_active = 1; m_base = col; m_beat = 0; m_len = len_of(code); m_il = il;
        end else if (m_active) begin
            if (st) m_active = 0;
            else if (m_len != 0 && m_beat == m_len - 1) m_active = 0;
            else m_beat = (m_beat + 1) % PG;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 3'b000, 0, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(col_valid == 1'b0 && col_last == 1'b0, "R1 reset", int'(col_valid), 0);
        rst = 1'b0;
        // directed: linear 8 from 5 (R3)
        step(1, 5, 3'b011, 0, 0); idle(9);
        // XOR 8 from 5 (R4), XOR 4 from 0x1F2, XOR 2
        step(1, 5, 3'b011, 1, 0); idle(9);
        step(1, 9'h1F2, 3'b010, 1, 0); idle(5);
        step(1, 9'h0A3, 3'b001, 1, 0); idle(3);
        // linear 4 crossing group (R3)
        step(1, 9'h0FE, 3'b010, 0, 0); idle(5);
        // single beat and unused codes (R7)
        step(1, 77, 3'b000, 0, 0); idle(2);
        step(1, 78, 3'b101, 1, 0); idle(2);
        // back-to-back starts interrupt (R2)
        step(1, 16, 3'b011, 0, 0); step(0, 0, 0, 0, 0);
        step(1, 300, 3'b010, 1, 1); idle(5);
        // full page with XOR request ignored, wraps 511->0 (R5, R9)
        step(1, 500, 3'b111, 1, 0); idle(40);
        step(0, 0, 3'b000, 0, 1); idle(2);  // stop (R8)
        // stop during a fixed burst (R8)
        step(1, 40, 3'b011, 0, 0); idle(2); step(0, 0, 0, 0, 1); idle(2);
        // random traffic
        for (int i = 0; i < 4000; i++) begin
            bit s = ($urandom % 6) == 0;
            int pick = $urandom % 6;
            logic [2:0] c;
            case (pick)
                0: c = 3'b000; 1: c = 3'b001; 2: c = 3'b010;
                3: c = 3'b011; 4: c = 3'b111; default: c = 3'(4 + ($urandom % 3));
            endcase
            step(s, int'($urandom % PG), c, 1'($urandom % 2), ($urandom % 25) == 0);
        end
        idle(2);
        @(negedge clk);
        check_outputs();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule